// File: doc/BRIEF.md
# Adaptive-Window Stereo Disparity Matcher

This block finds the horizontal disparity of one left-image pixel in a rectified stereo pair. It takes the 7×7 grayscale neighbourhood of the pixel and the strip of right-image pixels that every candidate shift can reach. It first measures how much the intensity varies near the pixel. From that measure it picks a 2×2, 5×5 or 7×7 aggregation window. It then sweeps the candidate disparities, one per clock, and reports the shift whose sum of absolute differences is lowest.

The variation test has two stages. A small window anchored at the pixel is measured first. If it carries enough texture, that small window is used. If it does not, a 5×5 window centred on the pixel is measured. If neither carries enough texture, the full 7×7 window is used. Both texture thresholds are inputs and can change from one pixel to the next. A line-buffer register bank upstream supplies all pixel data in parallel with a one-cycle start strobe. A result is returned with a one-cycle done strobe.

Top module: `sad_disp_matcher`

## Requirements
- R1: While reset is high and after it, until the first result, done_o, disp_o, tie_o are 0 and win_o is 0.
- R2: Let m be floor(sum/4) of the four pixels at window rows 3..4 and columns 3..4. The small-window variation is the sum over those four pixels of |p − m|. When it is greater than or equal to thr_small, the 2×2 window (win_o = 0) is used.
- R3: Let S be the sum of the 25 pixels at rows 1..5 and columns 1..5. The mid variation is the sum over those pixels of |25·p − S|. When R2 does not select the small window and the mid variation is at least thr_mid, the 5×5 window (win_o = 1) is used.
- R4: When neither test passes, the 7×7 window (win_o = 2) is used.
- R5: For candidate d (0..D_RANGE−1), left pixel (r,c) is compared with right-strip pixel (r, c + D_RANGE − 1 − d). Only pixels inside the chosen window contribute to the cost. Left pixel (r,c) sits at bits [(r·7+c)·8 +: 8] of left_win. Strip pixel (r,k) sits at bits [(r·(D_RANGE+6)+k)·8 +: 8] of right_strip.
- R6: disp_o is the candidate d with the lowest cost.
- R7: When several candidates share the lowest cost, disp_o is the smallest of them and tie_o is 1. Otherwise tie_o is 0.
- R8: The result appears with done_o high for exactly one cycle, D_RANGE+1 clock edges after the edge that accepted start.
- R9: A start pulse that arrives while a sweep is running is ignored. Outputs only change in the cycle in which done_o is high.
- R10: The small-window mean truncates. For pixels 0,0,0,3 the variation is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept inputs and begin a sweep (taken only when idle) |
| thr_small | input | PIX_W+2 | Texture threshold for the 2×2 window |
| thr_mid | input | PIX_W+10 | Texture threshold for the 5×5 window (scaled by 25) |
| left_win | input | 49·PIX_W | 7×7 left neighbourhood, row-major |
| right_strip | input | 7·(D_RANGE+6)·PIX_W | Right-image strip, row-major |
| done_o | output | 1 | One-cycle result strobe |
| disp_o | output | clog2(D_RANGE) | Disparity with lowest cost |
| win_o | output | 2 | Window used: 0 = 2×2, 1 = 5×5, 2 = 7×7 |
| tie_o | output | 1 | More than one candidate reached the lowest cost |

## Verification
The hardest case to reach from the ports is a pixel whose winning disparity depends on the window that was chosen. The small window must match perfectly at one shift, while only the large window singles out a different shift. To build it, the bench makes a scene with a clean match at one disparity. It then copies the four centre left pixels into the strip columns of a second shift. The same data is then swept under three threshold settings, and each setting must give its own expected disparity and tie flag. Threshold equality and the truncating mean are reached by computing the variation in the bench and setting each threshold to exactly that value, and to one above it.

// File: rtl/sad_disp_pkg.sv
package sad_disp_pkg;

  localparam int WIN_DIM = 7;
  localparam int CENTER  = 3;

  typedef enum logic [1:0] {
    WIN_2X2 = 2'd0,
    WIN_5X5 = 2'd1,
    WIN_7X7 = 2'd2
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_SCAN = 2'd2
  } state_e;

  // Membership of neighbourhood position (r,c) in a window shape.
  function automatic logic sad_in_window(win_e w, int r, int c);
    case (w)
      WIN_2X2: return (r >= CENTER) && (r <= CENTER + 1) &&
                      (c >= CENTER) && (c <= CENTER + 1);
      WIN_5X5: return (r >= CENTER - 2) && (r <= CENTER + 2) &&
                      (c >= CENTER - 2) && (c <= CENTER + 2);
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sad_win_select.sv
module sad_win_select
  import sad_disp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int VAR2_W = PIX_W + 2,
  parameter int VAR5_W = PIX_W + 10
) (
  input  logic [PIX_W-1:0]  pix [WIN_DIM][WIN_DIM],
  input  logic [VAR2_W-1:0] thr_small,
  input  logic [VAR5_W-1:0] thr_mid,
  output win_e              sel
);

  logic [VAR2_W-1:0] sum4;
  logic [PIX_W-1:0]  mean4;
  logic [PIX_W-1:0]  d4;
  logic [VAR2_W-1:0] var2;
  logic [VAR5_W-1:0] sum25;
  logic [VAR5_W-1:0] scaled;
  logic [VAR5_W-1:0] var5;

  always_comb begin
    sum4 = '0;
    for (int r = CENTER; r <= CENTER + 1; r++)
      for (int c = CENTER; c <= CENTER + 1; c++)
        sum4 = sum4 + VAR2_W'(pix[r][c]);
    mean4 = PIX_W'(sum4 >> 2);
    var2  = '0;
    d4    = '0;
    for (int r = CENTER; r <= CENTER + 1; r++)
      for (int c = CENTER; c <= CENTER + 1; c++) begin
        d4   = (pix[r][c] >= mean4) ? (pix[r][c] - mean4) : (mean4 - pix[r][c]);
        var2 = var2 + VAR2_W'(d4);
      end
  end

  always_comb begin
    sum25 = '0;
    for (int r = CENTER - 2; r <= CENTER + 2; r++)
      for (int c = CENTER - 2; c <= CENTER + 2; c++)
        sum25 = sum25 + VAR5_W'(pix[r][c]);
    var5   = '0;
    scaled = '0;
    for (int r = CENTER - 2; r <= CENTER + 2; r++)
      for (int c = CENTER - 2; c <= CENTER + 2; c++) begin
        scaled = VAR5_W'(pix[r][c]) * VAR5_W'(25);
        var5   = var5 + ((scaled >= sum25) ? (scaled - sum25) : (sum25 - scaled));
      end
  end

  always_comb begin
    if (var2 >= thr_small)     sel = WIN_2X2;
    else if (var5 >= thr_mid)  sel = WIN_5X5;
    else                       sel = WIN_7X7;
  end

endmodule

// File: rtl/sad_cost_unit.sv
module sad_cost_unit
  import sad_disp_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int D_RANGE = 16,
  parameter int D_W     = $clog2(D_RANGE),
  parameter int SW      = WIN_DIM + D_RANGE - 1,
  parameter int COST_W  = PIX_W + 6
) (
  input  logic [PIX_W-1:0]  lpix [WIN_DIM][WIN_DIM],
  input  logic [PIX_W-1:0]  rpix [WIN_DIM][SW],
  input  logic [D_W-1:0]    cand,
  input  win_e              win,
  output logic [COST_W-1:0] cost
);

  localparam int IDX_W = $clog2(SW);

  logic [IDX_W-1:0] idx;
  logic [PIX_W-1:0] rv;
  logic [PIX_W-1:0] ad;

  always_comb begin
    cost = '0;
    idx  = '0;
    rv   = '0;
    ad   = '0;
    for (int r = 0; r < WIN_DIM; r++)
      for (int c = 0; c < WIN_DIM; c++) begin
        if (sad_in_window(win, r, c)) begin
          idx  = IDX_W'(D_RANGE - 1 + c) - IDX_W'(cand);
          rv   = rpix[r][idx];
          ad   = (lpix[r][c] >= rv) ? (lpix[r][c] - rv) : (rv - lpix[r][c]);
          cost = cost + COST_W'(ad);
        end
      end
  end

endmodule

// File: rtl/sad_argmin.sv
module sad_argmin #(
  parameter int COST_W = 14,
  parameter int D_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              first,
  input  logic [COST_W-1:0] cost,
  input  logic [D_W-1:0]    cand,
  output logic [D_W-1:0]    fin_d,
  output logic              fin_tie
);

  logic [COST_W-1:0] best_c, nxt_c;
  logic [D_W-1:0]    best_d, nxt_d;
  logic              tie_r,  nxt_t;

  // Strict less-than keeps the earliest (smallest) candidate on a tie.
  always_comb begin
    nxt_c = best_c;
    nxt_d = best_d;
    nxt_t = tie_r;
    if (first) begin
      nxt_c = cost;
      nxt_d = cand;
      nxt_t = 1'b0;
    end else if (cost < best_c) begin
      nxt_c = cost;
      nxt_d = cand;
      nxt_t = 1'b0;
    end else if (cost == best_c) begin
      nxt_t = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_c <= '0;
      best_d <= '0;
      tie_r  <= 1'b0;
    end else if (en) begin
      best_c <= nxt_c;
      best_d <= nxt_d;
      tie_r  <= nxt_t;
    end
  end

  assign fin_d   = nxt_d;
  assign fin_tie = nxt_t;

endmodule

// File: rtl/sad_disp_matcher.sv
module sad_disp_matcher
  import sad_disp_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int D_RANGE = 16,
  parameter int THR1_W  = PIX_W + 2,
  parameter int THR2_W  = PIX_W + 10
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       start,
  input  logic [THR1_W-1:0]                          thr_small,
  input  logic [THR2_W-1:0]                          thr_mid,
  input  logic [WIN_DIM*WIN_DIM*PIX_W-1:0]           left_win,
  input  logic [WIN_DIM*(WIN_DIM+D_RANGE-1)*PIX_W-1:0] right_strip,
  output logic                                       done_o,
  output logic [$clog2(D_RANGE)-1:0]                 disp_o,
  output logic [1:0]                                 win_o,
  output logic                                       tie_o
);

  localparam int D_W    = $clog2(D_RANGE);
  localparam int SW     = WIN_DIM + D_RANGE - 1;
  localparam int COST_W = PIX_W + 6;
  localparam logic [D_W-1:0] LAST = D_W'(D_RANGE - 1);

  logic [PIX_W-1:0]  lw_in [WIN_DIM][WIN_DIM];
  logic [PIX_W-1:0]  rs_in [WIN_DIM][SW];
  logic [PIX_W-1:0]  lw_q  [WIN_DIM][WIN_DIM];
  logic [PIX_W-1:0]  rs_q  [WIN_DIM][SW];
  logic [THR1_W-1:0] t1_q;
  logic [THR2_W-1:0] t2_q;

  state_e            st;
  logic [D_W-1:0]    cnt;
  win_e              win_sel, win_q;
  logic [COST_W-1:0] cost;
  logic [D_W-1:0]    fin_d;
  logic              fin_tie;
  logic              accept;
  logic              scanning;

  always_comb begin
    for (int r = 0; r < WIN_DIM; r++) begin
      for (int c = 0; c < WIN_DIM; c++)
        lw_in[r][c] = left_win[(r*WIN_DIM + c)*PIX_W +: PIX_W];
      for (int k = 0; k < SW; k++)
        rs_in[r][k] = right_strip[(r*SW + k)*PIX_W +: PIX_W];
    end
  end

  assign accept   = (st == ST_IDLE) && start;
  assign scanning = (st == ST_SCAN);

  // Operand capture: data registers without reset.
  always_ff @(posedge clk) begin
    if (accept) begin
      lw_q <= lw_in;
      rs_q <= rs_in;
      t1_q <= thr_small;
      t2_q <= thr_mid;
    end
  end

  sad_win_select #(
    .PIX_W (PIX_W),
    .VAR2_W(THR1_W),
    .VAR5_W(THR2_W)
  ) u_sel (
    .pix      (lw_q),
    .thr_small(t1_q),
    .thr_mid  (t2_q),
    .sel      (win_sel)
  );

  sad_cost_unit #(
    .PIX_W  (PIX_W),
    .D_RANGE(D_RANGE),
    .D_W    (D_W),
    .SW     (SW),
    .COST_W (COST_W)
  ) u_cost (
    .lpix(lw_q),
    .rpix(rs_q),
    .cand(cnt),
    .win (win_q),
    .cost(cost)
  );

  sad_argmin #(
    .COST_W(COST_W),
    .D_W   (D_W)
  ) u_min (
    .clk    (clk),
    .rst    (rst),
    .en     (scanning),
    .first  (cnt == '0),
    .cost   (cost),
    .cand   (cnt),
    .fin_d  (fin_d),
    .fin_tie(fin_tie)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      win_q  <= WIN_2X2;
      done_o <= 1'b0;
      disp_o <= '0;
      win_o  <= 2'd0;
      tie_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start) st <= ST_SEL;
        ST_SEL: begin
          win_q <= win_sel;
          cnt   <= '0;
          st    <= ST_SCAN;
        end
        ST_SCAN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            disp_o <= fin_d;
            tie_o  <= fin_tie;
            win_o  <= win_q;
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sad_disp_matcher_chk.sv
module sad_disp_matcher_chk #(
  parameter int D_RANGE = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       done_o,
  input logic [$clog2(D_RANGE)-1:0] disp_o,
  input logic [1:0]                 win_o,
  input logic                       tie_o
);

  logic run;
  int   cyc;

  // Independent model of when a sweep is active and how long it has run.
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cyc <= 0;
    end else if (!run) begin
      if (start) begin
        run <= 1'b1;
        cyc <= 0;
      end
    end else if (done_o) begin
      run <= start;
      cyc <= 0;
    end else begin
      cyc <= cyc + 1;
    end
  end

  // R8: result strobe lands exactly D_RANGE+1 edges after acceptance
  a_r8_done_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run && (cyc == D_RANGE + 1)));

  // R8: strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: outputs hold between results
  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(disp_o) && $stable(win_o) && $stable(tie_o)));

  // R2/R3/R4: window code is one of the three legal encodings
  a_r4_win_legal: assert property (@(posedge clk) disable iff (rst)
    win_o != 2'd3);

  // R9: no strobe without an active sweep
  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !run |-> !done_o);

endmodule

bind sad_disp_matcher sad_disp_matcher_chk #(.D_RANGE(D_RANGE)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done_o(done_o),
  .disp_o(disp_o),
  .win_o (win_o),
  .tie_o (tie_o)
);

// File: tb/tb_sad_disp_matcher.sv
`timescale 1ns/1ps
module tb_sad_disp_matcher;

  localparam int PIX_W = 8;
  localparam int D     = 16;
  localparam int SW    = D + 6;
  localparam int D_W   = $clog2(D);

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [PIX_W+1:0] thr_small;
  logic [PIX_W+9:0] thr_mid;
  logic [49*PIX_W-1:0] left_win;
  logic [7*SW*PIX_W-1:0] right_strip;
  logic done_o;
  logic [D_W-1:0] disp_o;
  logic [1:0] win_o;
  logic tie_o;

  logic [7:0] lw [7][7];
  logic [7:0] rs [7][SW];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sad_disp_matcher #(.PIX_W(PIX_W), .D_RANGE(D)) dut (
    .clk(clk), .rst(rst), .start(start), .thr_small(thr_small), .thr_mid(thr_mid),
    .left_win(left_win), .right_strip(right_strip), .done_o(done_o),
    .disp_o(disp_o), .win_o(win_o), .tie_o(tie_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------- reference model ----------
  function automatic bit m_in(int w, int r, int c);
    if (w == 0) return r >= 3 && r <= 4 && c >= 3 && c <= 4;
    if (w == 1) return r >= 1 && r <= 5 && c >= 1 && c <= 5;
    return 1'b1;
  endfunction

  function automatic int m_var2();
    int s = 0, m, v = 0;
    for (int r = 3; r <= 4; r++) for (int c = 3; c <= 4; c++) s += lw[r][c];
    m = s / 4;
    for (int r = 3; r <= 4; r++) for (int c = 3; c <= 4; c++)
      v += (lw[r][c] >= m) ? lw[r][c] - m : m - lw[r][c];
    return v;
  endfunction

  function automatic int m_var5();
    int s = 0, v = 0, p;
    for (int r = 1; r <= 5; r++) for (int c = 1; c <= 5; c++) s += lw[r][c];
    for (int r = 1; r <= 5; r++) for (int c = 1; c <= 5; c++) begin
      p = 25 * lw[r][c];
      v += (p >= s) ? p - s : s - p;
    end
    return v;
  endfunction

  function automatic int m_win(int t1, int t2);
    if (m_var2() >= t1) return 0;
    if (m_var5() >= t2) return 1;
    return 2;
  endfunction

  function automatic int m_sad(int w, int d);
    int s = 0, a, b;
    for (int r = 0; r < 7; r++) for (int c = 0; c < 7; c++)
      if (m_in(w, r, c)) begin
        a = lw[r][c];
        b = rs[r][D - 1 + c - d];
        s += (a >= b) ? a - b : b - a;
      end
    return s;
  endfunction

  task automatic m_best(input int w, output int bd, output int bt);
    int best = 1 << 30, cst;
    bd = 0; bt = 0;
    for (int d = 0; d < D; d++) begin
      cst = m_sad(w, d);
      if (cst < best) begin best = cst; bd = d; bt = 0; end
      else if (cst == best) bt = 1;
    end
  endtask

  // ---------- stimulus helpers ----------
  function automatic int pat(int seed, int r, int x);
    return (r * 37 + x * x * 13 + x * 71 + seed * 29) & 255;
  endfunction

  task automatic scene(input int seed, input int dt);
    for (int r = 0; r < 7; r++) begin
      for (int c = 0; c < 7; c++) lw[r][c] = 8'(pat(seed, r, c + 20));
      for (int k = 0; k < SW; k++) rs[r][k] = 8'(pat(seed, r, k - (D - 1) + dt + 20));
    end
  endtask

  task automatic pack();
    for (int r = 0; r < 7; r++) begin
      for (int c = 0; c < 7; c++) left_win[(r*7 + c)*8 +: 8] = lw[r][c];
      for (int k = 0; k < SW; k++) right_strip[(r*SW + k)*8 +: 8] = rs[r][k];
    end
  endtask

  task automatic run_case(input int t1, input int t2, output int lat);
    pack();
    thr_small = 10'(t1);
    thr_mid   = 18'(t2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_vs_model(input string req, input int t1, input int t2);
    int lat, ew, ed, et;
    ew = m_win(t1, t2);
    m_best(ew, ed, et);
    run_case(t1, t2, lat);
    chk({req, " win"}, win_o, ew);
    chk({req, " disp"}, disp_o, ed);
    chk({req, " tie"}, tie_o, et);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    chk("R1 done", done_o, 0);
    chk("R1 disp", disp_o, 0);
    chk("R1 win", win_o, 0);
    chk("R1 tie", tie_o, 0);
  endtask

  task automatic t_clean_shift();
    int lat;
    int dts [3] = '{5, 0, D - 1};
    foreach (dts[i]) begin
      scene(i + 1, dts[i]);
      run_case(1023, 262143, lat);
      chk("R8 latency", lat, D + 1);
      chk("R4 win 7x7", win_o, 2);
      chk("R5/R6 disp", disp_o, dts[i]);
      chk("R6 tie", tie_o, 0);
      @(negedge clk);
      chk("R8 single strobe", done_o, 0);
    end
  endtask

  task automatic t_window_dependent();
    int lat;
    scene(7, 9);
    for (int r = 3; r <= 4; r++) for (int c = 3; c <= 4; c++) rs[r][D - 1 + c - 2] = lw[r][c];
    run_case(0, 0, lat);
    chk("R2 win 2x2", win_o, 0);
    chk("R7 smallest tied disp", disp_o, 2);
    chk("R7 tie flag", tie_o, 1);
    run_case(1023, 0, lat);
    chk("R3 win 5x5", win_o, 1);
    chk("R5 5x5 disp", disp_o, 9);
    chk("R5 5x5 tie", tie_o, 0);
    run_case(1023, 262143, lat);
    chk("R4 win 7x7", win_o, 2);
    chk("R6 7x7 disp", disp_o, 9);
  endtask

  task automatic t_thresholds();
    int v2, v5;
    scene(3, 4);
    v2 = m_var2();
    v5 = m_var5();
    run_vs_model("R2 thr equal", v2, 0);
    chk("R2 equality picks 2x2", win_o, 0);
    run_vs_model("R3 thr1 above", v2 + 1, v5);
    chk("R3 equality picks 5x5", win_o, 1);
    run_vs_model("R4 thr2 above", v2 + 1, v5 + 1);
    chk("R4 falls to 7x7", win_o, 2);
  endtask

  task automatic t_truncation();
    int lat;
    scene(5, 6);
    lw[3][3] = 0; lw[3][4] = 0; lw[4][3] = 0; lw[4][4] = 3;
    run_case(3, 262143, lat);
    chk("R10 var 3 meets thr 3", win_o, 0);
    run_case(4, 0, lat);
    chk("R10 var 3 below thr 4", win_o, 1);
  endtask

  task automatic t_ties();
    int lat;
    for (int r = 0; r < 7; r++) begin
      for (int c = 0; c < 7; c++) lw[r][c] = 8'd100;
      for (int k = 0; k < SW; k++) rs[r][k] = 8'd100;
    end
    run_case(1023, 262143, lat);
    chk("R7 flat disp", disp_o, 0);
    chk("R7 flat tie", tie_o, 1);
    for (int r = 0; r < 7; r++) begin
      for (int c = 0; c < 7; c++) lw[r][c] = 8'(((c + 20) % 5) * 50 + r * 7);
      for (int k = 0; k < SW; k++) rs[r][k] = 8'(((k - (D - 1) + 3 + 20) % 5) * 50 + r * 7);
    end
    run_case(1023, 262143, lat);
    chk("R7 periodic disp", disp_o, 3);
    chk("R7 periodic tie", tie_o, 1);
  endtask

  task automatic t_busy();
    int n, seen;
    scene(11, 12);
    pack();
    thr_small = '1; thr_mid = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    scene(12, 1);
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 3;
    while (!done_o && n < 1000) begin @(negedge clk); n++; end
    chk("R9 latency unaffected", n, D + 1);
    chk("R9 first data kept", disp_o, 12);
    seen = 0;
    for (int i = 0; i < D + 4; i++) begin
      @(negedge clk);
      if (done_o) seen++;
      if (disp_o != 12) seen += 100;
    end
    chk("R9 no second result, outputs held", seen, 0);
  endtask

  task automatic t_model_sweep();
    for (int i = 0; i < 6; i++) begin
      scene(20 + i, (i * 5) % D);
      run_vs_model("R6 sweep", (i * 97) % 400, (i * 4111) % 20000);
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; thr_small = '0; thr_mid = '0;
    left_win = '0; right_strip = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean_shift();
    t_window_dependent();
    t_thresholds();
    t_truncation();
    t_ties();
    t_busy();
    t_model_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule